// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Watchdog

This block carries one logic level across a link that can only pass short pulses, in the way a digital isolator channel does. The sending half, `pl_edge_tx`, watches the level input. A rising edge becomes a single one-cycle pulse on a set line. A falling edge becomes a single one-cycle pulse on a separate clear line. When the input stays still, the sender repeats the present level as a refresh pulse at a fixed interval. The receiver can then recover the correct level even if it missed an edge.

The receiving half, `pl_rx_latch`, is a set/clear latch driven by those two pulse lines. A watchdog counts the cycles since the last pulse. If the link stays silent for longer than the watchdog interval, the receiver treats the sender as dead and drives its output to a safe default high level. The first pulse that arrives after that restores normal tracking.

The top module puts both halves on one clock. The link sits between them behind a continuity input, which models a cut or silent barrier. Both intervals are parameters counted in clock cycles: `REFRESH_CYC` (default 16) and `WDOG_CYC` (default 80). `WDOG_CYC` must be larger than `REFRESH_CYC`, and `REFRESH_CYC` must be at least 2.

The sender runs a two-state machine:
- TX_LAUNCH is the cycle after reset. It always emits a pulse for the present level and then moves to TX_WATCH.
- TX_WATCH stays in place and does one of three things each cycle:
  - On an edge, it emits the edge pulse and restarts its counter.
  - When the refresh count runs out, it emits a refresh pulse and restarts its counter.
  - Otherwise it counts.

The receiver also has two states:
- RX_DEFAULT holds the output high and is left on any pulse (transition: revive).
- RX_TRACK follows the pulses. It falls back to RX_DEFAULT when the watchdog count runs out (transition: expire).

Top module: `pl_link_top`

## Requirements
- R1: A low-to-high change of `lvl_in` that is sampled at a clock edge makes `set_pulse` high for exactly the one following cycle, while `clr_pulse` stays low.
- R2: A high-to-low change of `lvl_in` that is sampled at a clock edge makes `clr_pulse` high for exactly the one following cycle, while `set_pulse` stays low.
- R3: `set_pulse` and `clr_pulse` are never high in the same cycle. When an edge and a refresh fall due in the same cycle, the edge pulse is sent and the refresh count restarts.
- R4: While `lvl_in` stays unchanged, a pulse that repeats the present level goes out every `REFRESH_CYC` cycles, counted from the previous pulse. A high level uses `set_pulse` and a low level uses `clr_pulse`. Any edge restarts this count.
- R5: A pulse received on the set line drives `lvl_out` to 1 on the next clock edge, and a pulse received on the clear line drives it to 0. Between pulses the output holds. With the link intact, `lvl_out` equals the value `lvl_in` had two clock edges earlier.
- R6: If no pulse is received on either line for `WDOG_CYC` consecutive cycles, `lvl_out` is forced to 1. It is first 1 on the clock edge that is `WDOG_CYC` edges after the edge that received the last pulse.
- R7: After the watchdog has fired, `lvl_out` stays 1 until the first received pulse. That pulse sets `lvl_out` on the very next clock edge.
- R8: `rst` is synchronous and active high. While it is held, both pulse lines are 0 and `lvl_out` is 1. On the first edge after release, the sender emits a pulse for the present `lvl_in` level.
- R9: While `link_ok` is 0, no pulse reaches the receiver. The sender's pulse lines carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by sender and receiver |
| rst | input | 1 | Synchronous active-high reset |
| lvl_in | input | 1 | Level to be carried across the link |
| link_ok | input | 1 | Link continuity; 0 blocks all pulses from reaching the receiver |
| set_pulse | output | 1 | Sender set line: one-cycle pulse for a rising edge or a high refresh |
| clr_pulse | output | 1 | Sender clear line: one-cycle pulse for a falling edge or a low refresh |
| lvl_out | output | 1 | Recovered level, forced high after link silence |

## Verification
The checker module checks several rules on every cycle:
- The two pulse lines are never high together, and every pulse is one cycle wide.
- Each pulse matches the level sampled one edge before it, and no sender gap reaches the refresh interval.
- A received pulse shows up at the output on the next edge.
- After the watchdog interval of silence the output is high.
- The output and both lines take their reset values.

Other behaviour needs a scenario that only the bench sets up:
- The exact edge on which the watchdog fires after a cut link.
- Revival on the first pulse after an expiry, with an edge and a link restore landing together.
- The exact count of refresh pulses over long idle stretches.
- Two-cycle tracking under random toggling.

// File: rtl/pl_pkg.sv
package pl_pkg;

    typedef enum logic [0:0] {
        TX_LAUNCH = 1'b0,
        TX_WATCH  = 1'b1
    } tx_state_e;

    typedef enum logic [0:0] {
        RX_DEFAULT = 1'b0,
        RX_TRACK   = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic set_p;
        logic clr_p;
    } pulse_pair_t;

endpackage

// File: rtl/pl_edge_tx.sv
module pl_edge_tx
    import pl_pkg::*;
#(
    parameter int REFRESH_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_in,
    output pulse_pair_t pulses
);

    localparam int CNT_W = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_CYC - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;
    logic             edge_seen;
    logic             fire;
    logic             restart;

    assign edge_seen = (lvl_in != prev_q);

    // Next-state and pulse decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            TX_LAUNCH: begin
                fire    = 1'b1;
                restart = 1'b1;
                state_d = TX_WATCH;
            end
            TX_WATCH: begin
                if (edge_seen) begin
                    fire    = 1'b1;
                    restart = 1'b1;
                end else if (cnt_q == CNT_LAST) begin
                    fire    = 1'b1;
                    restart = 1'b1;
                end
            end
            default: state_d = TX_LAUNCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_LAUNCH;
            prev_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= lvl_in;
            if (restart) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output register: the level decides the line, so both can never fire
    always_ff @(posedge clk) begin
        if (rst) begin
            pulses <= '0;
        end else begin
            pulses.set_p <= fire &  lvl_in;
            pulses.clr_p <= fire & ~lvl_in;
        end
    end

endmodule

// File: rtl/pl_rx_latch.sv
module pl_rx_latch
    import pl_pkg::*;
#(
    parameter int WDOG_CYC = 80
) (
    input  logic        clk,
    input  logic        rst,
    input  pulse_pair_t pulses,
    output logic        lvl_out
);

    localparam int WD_W = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYC - 1);

    rx_state_e       state_q, state_d;
    logic [WD_W-1:0] wd_q;
    logic            any_pulse;
    logic            expire;

    assign any_pulse = pulses.set_p | pulses.clr_p;

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        unique case (state_q)
            RX_DEFAULT: begin
                if (any_pulse) state_d = RX_TRACK;      // revive
            end
            RX_TRACK: begin
                if (!any_pulse && wd_q == WD_LAST) begin
                    expire  = 1'b1;                     // expire
                    state_d = RX_DEFAULT;
                end
            end
            default: state_d = RX_DEFAULT;
        endcase
    end

    // State register and watchdog count
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_DEFAULT;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (any_pulse || state_q == RX_DEFAULT) wd_q <= '0;
            else if (!expire)                       wd_q <= wd_q + 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)               lvl_out <= 1'b1;
        else if (pulses.set_p) lvl_out <= 1'b1;
        else if (pulses.clr_p) lvl_out <= 1'b0;
        else if (expire)       lvl_out <= 1'b1;
    end

endmodule

// File: rtl/pl_link_top.sv
module pl_link_top
    import pl_pkg::*;
#(
    parameter int REFRESH_CYC = 16,
    parameter int WDOG_CYC    = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    input  logic link_ok,
    output logic set_pulse,
    output logic clr_pulse,
    output logic lvl_out
);

    pulse_pair_t tx_lines;
    pulse_pair_t rx_lines;

    pl_edge_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (lvl_in),
        .pulses (tx_lines)
    );

    // Barrier path: a broken link passes nothing
    assign rx_lines.set_p = tx_lines.set_p & link_ok;
    assign rx_lines.clr_p = tx_lines.clr_p & link_ok;

    pl_rx_latch #(.WDOG_CYC(WDOG_CYC)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .pulses  (rx_lines),
        .lvl_out (lvl_out)
    );

    assign set_pulse = tx_lines.set_p;
    assign clr_pulse = tx_lines.clr_p;

endmodule

// File: rtl/pl_link_chk.sv
module pl_link_chk #(
    parameter int REFRESH_CYC = 16,
    parameter int WDOG_CYC    = 80
) (
    input logic clk,
    input logic rst,
    input logic lvl_in,
    input logic link_ok,
    input logic set_pulse,
    input logic clr_pulse,
    input logic lvl_out
);

    localparam int SIL_W = $clog2(WDOG_CYC + 2);
    localparam int GAP_W = $clog2(REFRESH_CYC + 2);

    logic [SIL_W-1:0] sil_q;
    logic [GAP_W-1:0] gap_q;
    logic             rx_set, rx_clr;

    assign rx_set = set_pulse & link_ok;
    assign rx_clr = clr_pulse & link_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sil_q <= '0;
            gap_q <= '0;
        end else begin
            if (rx_set || rx_clr)              sil_q <= '0;
            else if (sil_q != SIL_W'(WDOG_CYC)) sil_q <= sil_q + 1'b1;
            if (set_pulse || clr_pulse)           gap_q <= '0;
            else if (gap_q != GAP_W'(REFRESH_CYC)) gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (lvl_in && !$past(lvl_in)) |=> (set_pulse && !clr_pulse));
    a_r1_set_narrow: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> !set_pulse);
    a_r2_fall_clears: assert property (@(posedge clk) disable iff (rst)
        (!lvl_in && $past(lvl_in)) |=> (clr_pulse && !set_pulse));
    a_r2_clr_narrow: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(set_pulse && clr_pulse));
    a_r4_refresh_bound: assert property (@(posedge clk) disable iff (rst)
        gap_q < GAP_W'(REFRESH_CYC));
    a_r4_level_match: assert property (@(posedge clk) disable iff (rst)
        (set_pulse |-> $past(lvl_in)) and (clr_pulse |-> !$past(lvl_in)));
    a_r5_set_tracks: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> lvl_out);
    a_r5_clr_tracks: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> !lvl_out);
    a_r6_silence_high: assert property (@(posedge clk) disable iff (rst)
        (sil_q == SIL_W'(WDOG_CYC)) |-> lvl_out);
    a_r8_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lvl_out && !set_pulse && !clr_pulse));

endmodule

bind pl_link_top pl_link_chk #(
    .REFRESH_CYC (REFRESH_CYC),
    .WDOG_CYC    (WDOG_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lvl_in    (lvl_in),
    .link_ok   (link_ok),
    .set_pulse (set_pulse),
    .clr_pulse (clr_pulse),
    .lvl_out   (lvl_out)
);

// File: tb/sim_pl_link_top.sv
module sim_pl_link_top;

    localparam int REFRESH = 16;
    localparam int WDOG    = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lvl_in = 1'b0;
    logic link_ok = 1'b1;
    logic set_pulse, clr_pulse, lvl_out;

    int n_chk = 0;
    int n_fail = 0;
    logic h1, h2;

    always #2 clk = ~clk;

    pl_link_top #(.REFRESH_CYC(REFRESH), .WDOG_CYC(WDOG)) u0 (
        .clk(clk), .rst(rst), .lvl_in(lvl_in), .link_ok(link_ok),
        .set_pulse(set_pulse), .clr_pulse(clr_pulse), .lvl_out(lvl_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected receiver output: input level two edges back while link is up
    function automatic logic exp_track(input logic two_back);
        return two_back;
    endfunction

    // Expected number of pulses in a window of w cycles after an edge pulse
    function automatic int exp_pulses(input int w);
        return (w - 1) / REFRESH + 1;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_window(input int w, output int ns, output int nc);
        ns = 0; nc = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (set_pulse) ns++;
            if (clr_pulse) nc++;
            chk(!(set_pulse && clr_pulse), "R3 both lines", 1, 0);
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL run timeout R1..all actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int ns, nc;
        void'($urandom(32'd4417));
        // R8: reset values
        tick(3);
        chk(lvl_out == 1'b1, "R8 reset out", lvl_out, 1);
        chk(!set_pulse && !clr_pulse, "R8 reset lines", {set_pulse, clr_pulse}, 0);
        rst = 1'b0;
        tick(1);
        chk(clr_pulse && !set_pulse, "R8 launch pulse", {set_pulse, clr_pulse}, 1);
        tick(1);
        chk(lvl_out == 1'b0, "R5 after launch", lvl_out, 0);
        chk(!clr_pulse, "R2 narrow launch", clr_pulse, 0);

        // R1: rising edge
        tick(5);
        lvl_in = 1'b1;
        tick(1);
        chk(set_pulse && !clr_pulse, "R1 set on rise", {set_pulse, clr_pulse}, 2);
        tick(1);
        chk(!set_pulse, "R1 one cycle", set_pulse, 0);
        chk(lvl_out == 1'b1, "R5 follows rise", lvl_out, 1);

        // R4: refresh while high, window starts with the previous pulse two edges back
        lvl_in = 1'b1;
        count_window(5 * REFRESH, ns, nc);
        chk(ns == exp_pulses(5 * REFRESH - 1) - 0, "R4 high refresh count", ns, exp_pulses(5 * REFRESH - 1));
        chk(nc == 0, "R4 no clear while high", nc, 0);

        // R2: falling edge, then R4 low refresh
        lvl_in = 1'b0;
        tick(1);
        chk(clr_pulse && !set_pulse, "R2 clear on fall", {set_pulse, clr_pulse}, 1);
        tick(1);
        chk(!clr_pulse, "R2 one cycle", clr_pulse, 0);
        chk(lvl_out == 1'b0, "R5 follows fall", lvl_out, 0);
        count_window(5 * REFRESH, ns, nc);
        chk(nc == exp_pulses(5 * REFRESH - 1), "R4 low refresh count", nc, exp_pulses(5 * REFRESH - 1));
        chk(ns == 0, "R4 no set while low", ns, 0);

        // R4/R3: edge restarts refresh count -> single pulse then next after REFRESH
        lvl_in = 1'b1;
        tick(1);
        chk(set_pulse, "R4 edge pulse", set_pulse, 1);
        count_window(REFRESH - 1, ns, nc);
        chk(ns == 0 && nc == 0, "R4 edge restarts count", ns + nc, 0);
        tick(1);
        chk(set_pulse, "R4 refresh after restart", set_pulse, 1);

        // R6/R9: exact watchdog expiry after cut
        lvl_in = 1'b0;
        tick(1);
        chk(clr_pulse, "R2 pulse before cut", clr_pulse, 1);
        tick(1);
        link_ok = 1'b0;
        ns = 0; nc = 0;
        for (int i = 0; i < WDOG - 1; i++) begin
            @(negedge clk);
            if (clr_pulse) nc++;
        end
        chk(lvl_out == 1'b0, "R6 holds before expiry", lvl_out, 0);
        chk(nc > 0, "R9 sender keeps refreshing", nc, 1);
        tick(1);
        chk(lvl_out == 1'b1, "R6 forced high on expiry", lvl_out, 1);

        // R9: pulses lost while cut
        lvl_in = 1'b1; tick(3); lvl_in = 1'b0; tick(3);
        chk(lvl_out == 1'b1, "R9 cut blocks pulses", lvl_out, 1);
        lvl_in = 1'b1;
        tick(2 * WDOG);
        chk(lvl_out == 1'b1, "R7 default held", lvl_out, 1);

        // R7: revival on first pulse
        link_ok = 1'b1;
        lvl_in = 1'b0;
        tick(1);
        chk(lvl_out == 1'b1, "R7 not yet", lvl_out, 1);
        tick(1);
        chk(lvl_out == 1'b0, "R7 revived", lvl_out, 0);

        // R5: random toggling and long idle stretches
        tick(3);
        h1 = lvl_in; h2 = lvl_in;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk(lvl_out == exp_track(h2), "R5 random track", lvl_out, h2);
            chk(!(set_pulse && clr_pulse), "R3 random", 1, 0);
            h2 = h1;
            if (($urandom % 64) == 0) begin
                h1 = lvl_in;
                for (int j = 0; j < int'($urandom % (3 * WDOG)); j++) begin
                    @(negedge clk);
                    chk(lvl_out == exp_track(h2), "R4 idle track", lvl_out, h2);
                    h2 = h1;
                end
            end
            if (($urandom % 4) == 0) lvl_in = ~lvl_in;
            h1 = lvl_in;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule